// File: doc/BRIEF.md
# Quadrature Sampler with LED Strobe

This block watches the two phase lines of an incremental motion encoder and takes one (A,B) sample per programmable interval. Each sample is compared with the pair taken one interval earlier and turned into a signed motion code: one step forward, one step back, no movement, or a double transition. A double transition means both lines changed between samples, which is usually a sign that the sample rate is too low for the shaft speed. Each new code is announced by a one-cycle ready strobe. Counting the codes and filtering the inputs are left to neighbouring blocks.

For optical encoders the block also drives an illumination output. The light comes on a programmable number of microseconds before each sample instant and goes off on the cycle after the sample. The drive level is selectable. While the neighbouring debounce filter is active, the light stays on for as long as the block runs. A clock-divider parameter derives a 1 µs tick from the system clock, and all interval and lead-time counting is done in those ticks. Start and stop commands gate the sampler. The period code should only be changed while the block is stopped.

Top module: `quad_sampler`

## Requirements
- R1: The sample interval is 128 µs × 2^code for a period code from 0 to 10, counted in 1 µs ticks of CLK_PER_US clock cycles. The first sample instant falls exactly one interval after the start command is taken, and further samples follow one interval apart.
- R2: The motion code is a 3-bit two's-complement value compared against the previous pair, with A as the upper bit of the pair. The forward steps 00→01, 01→11, 11→10 and 10→00 give +1 (3'b001). The reverse steps give −1 (3'b111). An unchanged pair gives 0 (3'b000). A change of both bits gives 2 (3'b010).
- R3: Every sample after the first raises the ready strobe for exactly one clock, in the cycle after the sample instant. The motion code holds its value between strobes.
- R4: The first sample after a start only loads the previous-pair register. It raises no ready strobe.
- R5: While running with debounce off and a lead time L below the interval I, the LED is active in microsecond slot k of the interval (k = 0 … I−1) exactly when k ≥ I − L. It therefore turns off in the cycle right after each sample.
- R6: When the lead time is equal to or longer than the interval, the LED is active for the whole time the block runs.
- R7: With polarity 1 the active LED level is high. With polarity 0 the active LED level is low. The inactive level is the complement of the active level.
- R8: While the debounce flag is set and the block runs, the LED stays active in every cycle.
- R9: A stop command gives a one-cycle stopped pulse in the following cycle. After a stop there are no further ready strobes and the LED is inactive.
- R10: After reset the block is stopped, the ready strobe and the stopped pulse are low, and the motion code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle start command; restarts timing and decode history |
| stop_i | input | 1 | One-cycle stop command; wins over start |
| per_code_i | input | 4 | Sample interval code, 0 to 10 (larger values act as 10) |
| lead_us_i | input | 9 | LED lead time before each sample, in µs |
| led_pol_i | input | 1 | LED active level: 1 high, 0 low |
| dbf_en_i | input | 1 | Debounce active; keeps the LED on while running |
| phase_a_i | input | 1 | Encoder phase A (asynchronous) |
| phase_b_i | input | 1 | Encoder phase B (asynchronous) |
| motion_o | output | 3 | Last motion code, two's complement |
| sample_rdy_o | output | 1 | One-cycle strobe for each new motion code |
| stopped_o | output | 1 | One-cycle pulse after a stop command |
| led_o | output | 1 | Illumination drive |

## Verification
The decoder is exercised with a full forward rotation and a full reverse rotation, which separate the +1 and −1 codes and check the wrap between 10 and 00. A seeded random walk of pairs mixes unchanged pairs, single steps and double transitions, so any mix-up between the 0 and 2 codes, or between the directions, shows up. The LED window is compared cycle by cycle under a short lead, a lead just below a long interval, a lead longer than the interval, and debounce on. Together these tell apart an off-by-one in the window edge, a missing saturation and a wrong polarity. Each run ends with a stop, after which strobes and light must stay quiet.

// File: rtl/qs_pkg.sv
package qs_pkg;
  typedef logic [2:0] motion_t;
  localparam motion_t MOT_NONE = 3'b000;
  localparam motion_t MOT_FWD  = 3'b001;
  localparam motion_t MOT_REV  = 3'b111;
  localparam motion_t MOT_DBL  = 3'b010;
endpackage

// File: rtl/qs_us_tick.sv
module qs_us_tick #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = run_i && (cnt_q == CW'(CLK_PER_US - 1));
    cnt_d  = cnt_q;
    if (restart_i)   cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else if (run_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/qs_timer.sv
module qs_timer #(
  parameter int CLK_PER_US = 125,
  parameter int BASE_US    = 128,
  parameter int MAX_CODE   = 10,
  parameter int LEAD_W     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [3:0]        per_code_i,
  input  logic [LEAD_W-1:0] lead_i,
  output logic              run_o,
  output logic              restart_o,
  output logic              stopped_o,
  output logic              sample_o,
  output logic              led_win_o
);
  localparam int US_W = $clog2(BASE_US << MAX_CODE) + 1;

  logic            run_q, run_d, stopped_q, tick;
  logic [US_W-1:0] us_q, us_d, interval, lead_ext;
  logic [3:0]      code_c;

  assign restart_o = start_i && !stop_i;

  qs_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .restart_i(restart_o), .tick_o(tick)
  );

  always_comb begin
    code_c   = (per_code_i > 4'(MAX_CODE)) ? 4'(MAX_CODE) : per_code_i;
    interval = US_W'(BASE_US) << code_c;
    lead_ext = US_W'(lead_i);
    sample_o = tick && (us_q >= interval - 1'b1);
    run_d    = run_q;
    if (stop_i)         run_d = 1'b0;
    else if (start_i)   run_d = 1'b1;
    us_d = us_q;
    if (restart_o)      us_d = '0;
    else if (sample_o)  us_d = '0;
    else if (tick)      us_d = us_q + 1'b1;
    led_win_o = run_q && ((lead_ext >= interval) || (us_q >= interval - lead_ext));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      stopped_q <= 1'b0;
      us_q      <= '0;
    end else begin
      run_q     <= run_d;
      stopped_q <= stop_i;
      us_q      <= us_d;
    end
  end

  assign run_o     = run_q;
  assign stopped_o = stopped_q;

  p_stop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (stopped_o && !run_o));
  p_sample_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> (us_q == '0));
  p_led_off_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && (lead_ext < interval)) |=>
      (!led_win_o || !$stable(lead_i) || !$stable(per_code_i)));
endmodule

// File: rtl/qs_decode.sv
module qs_decode
  import qs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    restart_i,
  input  logic    sample_i,
  input  logic    a_i,
  input  logic    b_i,
  output motion_t motion_o,
  output logic    rdy_o
);
  logic [SYNC_STAGES-1:0][1:0] sync_q, sync_d;
  logic [1:0] cur, prev_q, prev_d, step;
  logic       have_q, have_d, rdy_q, rdy_d;
  motion_t    mot_q, mot_d, code;

  function automatic logic [1:0] gray_pos(input logic [1:0] p);
    return {p[1], p[1] ^ p[0]};
  endfunction

  always_comb begin
    sync_d[0] = {a_i, b_i};
    for (int i = 1; i < SYNC_STAGES; i++) sync_d[i] = sync_q[i-1];
    cur  = sync_q[SYNC_STAGES-1];
    step = gray_pos(cur) - gray_pos(prev_q);
    case (step)
      2'd1:    code = MOT_FWD;
      2'd3:    code = MOT_REV;
      2'd2:    code = MOT_DBL;
      default: code = MOT_NONE;
    endcase
    prev_d = prev_q;
    have_d = have_q;
    mot_d  = mot_q;
    rdy_d  = 1'b0;
    if (restart_i) begin
      have_d = 1'b0;
    end else if (sample_i) begin
      prev_d = cur;
      have_d = 1'b1;
      if (have_q) begin
        rdy_d = 1'b1;
        mot_d = code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
      have_q <= 1'b0;
      mot_q  <= MOT_NONE;
      rdy_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      have_q <= have_d;
      mot_q  <= mot_d;
      rdy_q  <= rdy_d;
    end
  end

  assign motion_o = mot_q;
  assign rdy_o    = rdy_q;

  p_first_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !have_q && !restart_i) |=> !rdy_o);
  p_rdy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |=> !rdy_o);
  p_hold_motion_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_o |-> $stable(motion_o));
  p_double_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && have_q && !restart_i && ((cur ^ prev_q) == 2'b11)) |=> (motion_o == MOT_DBL));
endmodule

// File: rtl/quad_sampler.sv
module quad_sampler
  import qs_pkg::*;
#(
  parameter int CLK_PER_US  = 125,
  parameter int BASE_US     = 128,
  parameter int MAX_CODE    = 10,
  parameter int LEAD_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [3:0]        per_code_i,
  input  logic [LEAD_W-1:0] lead_us_i,
  input  logic              led_pol_i,
  input  logic              dbf_en_i,
  input  logic              phase_a_i,
  input  logic              phase_b_i,
  output logic [2:0]        motion_o,
  output logic              sample_rdy_o,
  output logic              stopped_o,
  output logic              led_o
);
  logic [1:0] rst_sync_q;
  logic       rs_n, run, restart, sample, led_win, led_act;
  motion_t    motion;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rs_n = rst_sync_q[1];

  qs_timer #(
    .CLK_PER_US(CLK_PER_US), .BASE_US(BASE_US), .MAX_CODE(MAX_CODE), .LEAD_W(LEAD_W)
  ) u_timer (
    .clk(clk), .rst_n(rs_n), .start_i(start_i), .stop_i(stop_i),
    .per_code_i(per_code_i), .lead_i(lead_us_i), .run_o(run),
    .restart_o(restart), .stopped_o(stopped_o), .sample_o(sample), .led_win_o(led_win)
  );

  qs_decode #(.SYNC_STAGES(SYNC_STAGES)) u_decode (
    .clk(clk), .rst_n(rs_n), .restart_i(restart), .sample_i(sample),
    .a_i(phase_a_i), .b_i(phase_b_i), .motion_o(motion), .rdy_o(sample_rdy_o)
  );

  assign motion_o = motion;
  assign led_act  = led_win || (run && dbf_en_i);
  assign led_o    = led_pol_i ? led_act : !led_act;

  p_dbf_led_on_r8: assert property (@(posedge clk) disable iff (!rs_n)
    (run && dbf_en_i) |-> (led_o == led_pol_i));
  p_idle_dark_r9: assert property (@(posedge clk) disable iff (!rs_n)
    !run |-> (led_o != led_pol_i));
endmodule

// File: tb/quad_sampler_bench.sv
module quad_sampler_bench;
  localparam int CPU = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, stop_i = 1'b0;
  logic [3:0] per_code_i = 4'd0;
  logic [8:0] lead_us_i = 9'd16;
  logic led_pol_i = 1'b1, dbf_en_i = 1'b0;
  logic phase_a_i = 1'b0, phase_b_i = 1'b0;
  logic [2:0] motion_o;
  logic sample_rdy_o, stopped_o, led_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  quad_sampler #(.CLK_PER_US(CPU)) u_quad_sampler (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .per_code_i(per_code_i), .lead_us_i(lead_us_i), .led_pol_i(led_pol_i),
    .dbf_en_i(dbf_en_i), .phase_a_i(phase_a_i), .phase_b_i(phase_b_i),
    .motion_o(motion_o), .sample_rdy_o(sample_rdy_o), .stopped_o(stopped_o), .led_o(led_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] step_fwd(input logic [1:0] p);
    case (p)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [2:0] exp_code(input logic [1:0] prev, input logic [1:0] cur);
    if (prev == cur)                 return 3'b000;
    if ((prev ^ cur) == 2'b11)       return 3'b010;
    if (cur == step_fwd(prev))       return 3'b001;
    return 3'b111;
  endfunction

  function automatic bit exp_led(input int m, input int ival, input int lead, input bit dbf, input bit pol);
    bit act;
    act = dbf || (lead >= ival) || (((m / CPU) % ival) >= (ival - lead));
    return pol ? act : !act;
  endfunction

  task automatic run_seq(input int code, input int lead, input bit pol, input bit dbf,
                         input int nsamp, input int mode, input string led_req);
    int ival, n, led_bad, rdy_bad, quiet_bad, k;
    logic [1:0] pr [0:63];
    logic [2:0] last;
    ival = 128 << code;
    n = ival * CPU;
    led_bad = 0; rdy_bad = 0; quiet_bad = 0;
    last = motion_o;
    pr[0] = 2'(mode == 0 ? $urandom % 4 : 0);
    for (int j = 1; j < 64; j++) begin
      if (mode == 0)      pr[j] = 2'($urandom % 4);
      else if (mode == 1) pr[j] = step_fwd(pr[j-1]);
      else                pr[j] = step_fwd(step_fwd(step_fwd(pr[j-1])));
    end
    @(negedge clk);
    per_code_i = 4'(code); lead_us_i = 9'(lead); led_pol_i = pol; dbf_en_i = dbf;
    {phase_a_i, phase_b_i} = pr[0];
    repeat (4) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int m = 1; m <= nsamp * n; m++) begin
      @(negedge clk);
      k = m / n;
      if ((m % n) == 0 && k == 1)
        check(sample_rdy_o == 1'b0, "R4", "first sample strobe", sample_rdy_o, 0);
      else if ((m % n) == 0) begin
        last = exp_code(pr[k-2], pr[k-1]);
        check(sample_rdy_o == 1'b1, "R1", "strobe at interval", sample_rdy_o, 1);
        check(motion_o == last, "R2", "motion code", motion_o, last);
      end else if (sample_rdy_o) rdy_bad++;
      if (led_o != exp_led(m, ival, lead, dbf, pol)) led_bad++;
      if ((m % n) == n / 2 && m > n) {phase_a_i, phase_b_i} = pr[k];
    end
    check(rdy_bad == 0, "R3", "strobes off schedule", rdy_bad, 0);
    check(motion_o == last, "R3", "motion held", motion_o, last);
    check(led_bad == 0, led_req, "led cycles wrong", led_bad, 0);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    check(stopped_o == 1'b1, "R9", "stopped pulse", stopped_o, 1);
    @(negedge clk);
    check(stopped_o == 1'b0, "R9", "stopped pulse width", stopped_o, 0);
    for (int m = 0; m < 2 * n; m++) begin
      @(negedge clk);
      if (sample_rdy_o || (led_o != !pol)) quiet_bad++;
      if ((m % 97) == 0) {phase_a_i, phase_b_i} = 2'($urandom % 4);
    end
    check(quiet_bad == 0, "R9", "activity after stop", quiet_bad, 0);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(sample_rdy_o == 1'b0, "R10", "strobe after reset", sample_rdy_o, 0);
    check(stopped_o == 1'b0, "R10", "stopped after reset", stopped_o, 0);
    check(motion_o == 3'b000, "R10", "motion after reset", motion_o, 0);
    check(led_o == 1'b0, "R10", "led after reset", led_o, 0);

    run_seq(0, 16, 1'b1, 1'b0, 10, 1, "R5");
    run_seq(0, 16, 1'b0, 1'b0, 10, 2, "R7");
    run_seq(1, 100, 1'b1, 1'b0, 20, 0, "R5");
    run_seq(0, 300, 1'b1, 1'b0, 8, 0, "R6");
    run_seq(0, 128, 1'b0, 1'b0, 6, 0, "R6");
    run_seq(0, 5, 1'b1, 1'b1, 8, 0, "R8");
    run_seq(2, 511, 1'b1, 1'b0, 5, 0, "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule